// File: doc/BRIEF.md
# Memory-to-Stream DMA Read Channel

This block moves a programmed run of 32-bit words from memory onto an outgoing valid/ready stream. Software sets a word-aligned start address, a high address word and a byte count through a small register port. Writing the byte count is the start command. The channel then issues one memory read at a time, and a memory agent answers each read with a response. Each returned word is pushed as one stream beat. The final beat can carry an end-of-packet marker.

As it goes, the channel adds every good word to a running 32-bit sum. It can reverse the byte order of the words it sends. It can also keep reading from one fixed address, for a peripheral data port that does not increment. Completion and read errors leave as one-cycle event pulses for an interrupt controller. A three-bit completion counter counts finished transfers.

Register select codes: 0 low address, 1 high address, 2 byte count, 3 control, 4 status, 5 checksum. Control bits: bit 0 memory pause, bit 1 stream pause, bit 2 fixed address, bit 3 byte reversal.

Top module: `strm_rd_chan`

## Requirements
- R1: After reset the channel is idle: busy, mem_req, s_valid and irq_evt are 0, and the count, control, status and checksum registers read 0.
- R2: The low address register (select 0) stores bits 31:2 and reads 0 in bits 1:0. The high address register (select 1) stores 17 bits. Writes to either are ignored while busy.
- R3: The count register (select 2) takes a byte count from bits 28:2 and a last-word flag from bit 0. A read returns the remaining byte count with the flag in bit 0. A count write while busy is ignored.
- R4: Writing a non-zero count sets busy. Words are read from consecutive addresses, stepping by 4 with carry into the high word, and are sent in address order. The remaining count falls by 4 on every accepted beat.
- R5: With control bit 2 set, every read uses the programmed address, and the address register is unchanged at the end.
- R6: Writing a count of zero moves no data and issues no read. Busy stays 0. Done events pulse once and the completion counter increments.
- R7: When the last beat is accepted, busy clears. irq_evt bit 1 (done) and bit 0 (memory done) pulse together for one cycle. The completion counter, read in status bits 3:1, increments modulo 8. Status bit 0 reads busy.
- R8: s_last is high only on the final beat of a transfer, and only if the last-word flag was written as 1.
- R9: Each word read without error is added, modulo 2^32, to the checksum register (select 5) before any byte reversal. The checksum can be written only while idle.
- R10: With control bit 3 set, each sent word has its four bytes in reversed order.
- R11: While control bit 0 or bit 1 is set, no new read is issued and s_valid is held low. Clearing both resumes the transfer, and it finishes with the correct data.
- R12: A read response with mem_rerr pulses irq_evt bit 2. That word is still sent, exactly as returned: it is not reversed and not added to the checksum.
- R13: mem_req stays high with a stable address until mem_rvalid, and at most one read is outstanding. s_data holds while s_valid is high and s_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | 49 | Byte address of the read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response error |
| s_valid | output | 1 | Stream beat valid |
| s_ready | input | 1 | Stream sink ready |
| s_data | output | 32 | Stream beat data |
| s_last | output | 1 | End-of-packet marker |
| busy | output | 1 | Transfer in progress |
| irq_evt | output | 3 | Event pulses: 0 memory done, 1 done, 2 read error |

## Verification
The assertions assume the memory agent answers only while mem_req is high and raises mem_rvalid for exactly one cycle per request. The bench memory keeps to this: it answers at a falling edge after a random 0 to 2 cycle wait, and it drops its response once the request has gone. The stream sink may lower s_ready at any time, and the assertions cover that case. Pause bits and count writes reach the block only through the register port, so every assertion about a stall sees the pause in its registered form.

// File: rtl/strm_rd_pkg.sv
package strm_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_FETCH,
        ST_SEND
    } st_e;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_ADDR_LO = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ADDR_HI = 3'd1;
    localparam logic [SEL_W-1:0] SEL_LEN     = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd3;
    localparam logic [SEL_W-1:0] SEL_STAT    = 3'd4;
    localparam logic [SEL_W-1:0] SEL_SUM     = 3'd5;

    // packed from MSB: bit3 swap, bit2 fixed, bit1 stream pause, bit0 memory pause
    typedef struct packed {
        logic swap;
        logic fixed;
        logic pause_strm;
        logic pause_mem;
    } ctrl_t;

endpackage

// File: rtl/strm_rd_bswap.sv
module strm_rd_bswap #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign dout[8*i +: 8] = din[8*(NB-1-i) +: 8];
    end

endmodule

// File: rtl/strm_rd_ctl.sv
module strm_rd_ctl
    import strm_rd_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LO_W  = 32,
    parameter int HI_W  = 17,
    parameter int LEN_W = 29,
    parameter int CNT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [SEL_W-1:0]       reg_sel,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic                   mem_req,
    output logic [LO_W+HI_W-1:0]   mem_addr,
    input  logic                   mem_rvalid,
    input  logic [DW-1:0]          mem_rdata,
    input  logic [DW-1:0]          mem_rdata_rev,
    input  logic                   mem_rerr,
    output logic                   s_valid,
    input  logic                   s_ready,
    output logic [DW-1:0]          s_data,
    output logic                   s_last,
    output logic                   busy,
    output logic                   paused,
    output logic [2:0]             irq_evt
);
    localparam int BYTES  = DW / 8;
    localparam int ALIGN  = $clog2(BYTES);
    localparam int ADDR_W = LO_W + HI_W;
    localparam logic [LEN_W-1:0]  STEP_LEN  = LEN_W'(BYTES);
    localparam logic [ADDR_W-1:0] STEP_ADDR = ADDR_W'(BYTES);

    typedef struct packed {
        st_e              st;
        logic [LO_W-1:0]  alo;
        logic [HI_W-1:0]  ahi;
        logic [LEN_W-1:0] len;
        logic             last;
        ctrl_t            ctrl;
        logic [DW-1:0]    sum;
        logic [DW-1:0]    wbuf;
        logic [CNT_W-1:0] dcnt;
        logic [2:0]       evt;
    } state_t;

    state_t q, d;

    logic              idle;
    logic              pause_any;
    logic              beat;
    logic [ADDR_W-1:0] addr_full;
    logic [ADDR_W-1:0] addr_next;
    logic [LEN_W-1:0]  wr_len;

    assign idle      = (q.st == ST_IDLE);
    assign pause_any = q.ctrl.pause_mem | q.ctrl.pause_strm;
    assign addr_full = {q.ahi, q.alo};
    assign addr_next = addr_full + STEP_ADDR;
    assign wr_len    = {reg_wdata[LEN_W-1:ALIGN], {ALIGN{1'b0}}};
    assign beat      = s_valid & s_ready;

    always_comb begin
        d     = q;
        d.evt = '0;

        if (reg_we) begin
            case (reg_sel)
                SEL_ADDR_LO: if (idle) d.alo = {reg_wdata[LO_W-1:ALIGN], {ALIGN{1'b0}}};
                SEL_ADDR_HI: if (idle) d.ahi = reg_wdata[HI_W-1:0];
                SEL_CTRL:    d.ctrl = ctrl_t'(reg_wdata[3:0]);
                SEL_SUM:     if (idle) d.sum = reg_wdata[DW-1:0];
                SEL_LEN: begin
                    if (idle) begin
                        d.len  = wr_len;
                        d.last = reg_wdata[0];
                        if (wr_len == '0) begin
                            d.evt  = 3'b011;
                            d.dcnt = q.dcnt + 1'b1;
                        end else begin
                            d.st = ST_ARM;
                        end
                    end
                end
                default: ;
            endcase
        end

        case (q.st)
            ST_ARM: begin
                if (!pause_any) d.st = ST_FETCH;
            end
            ST_FETCH: begin
                if (mem_rvalid) begin
                    d.st = ST_SEND;
                    if (mem_rerr) begin
                        d.wbuf   = mem_rdata;
                        d.evt[2] = 1'b1;
                    end else begin
                        d.wbuf = q.ctrl.swap ? mem_rdata_rev : mem_rdata;
                        d.sum  = q.sum + mem_rdata;
                    end
                end
            end
            ST_SEND: begin
                if (beat) begin
                    d.len = q.len - STEP_LEN;
                    if (!q.ctrl.fixed) {d.ahi, d.alo} = addr_next;
                    if (q.len == STEP_LEN) begin
                        d.st       = ST_IDLE;
                        d.evt[1:0] = 2'b11;
                        d.dcnt     = q.dcnt + 1'b1;
                    end else begin
                        d.st = ST_ARM;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_req  = (q.st == ST_FETCH);
    assign mem_addr = addr_full;
    assign s_valid  = (q.st == ST_SEND) & ~pause_any;
    assign s_data   = q.wbuf;
    assign s_last   = s_valid & q.last & (q.len == STEP_LEN);
    assign busy     = ~idle;
    assign paused   = pause_any;
    assign irq_evt  = q.evt;

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_ADDR_LO: reg_rdata[LO_W-1:0] = q.alo;
            SEL_ADDR_HI: reg_rdata[HI_W-1:0] = q.ahi;
            SEL_LEN: begin
                reg_rdata[LEN_W-1:0] = q.len;
                reg_rdata[0]         = q.last;
            end
            SEL_CTRL:    reg_rdata[3:0] = q.ctrl;
            SEL_STAT: begin
                reg_rdata[CNT_W:1] = q.dcnt;
                reg_rdata[0]       = busy;
            end
            SEL_SUM:     reg_rdata[DW-1:0] = q.sum;
            default: ;
        endcase
    end

endmodule

// File: rtl/strm_rd_chan.sv
module strm_rd_chan
    import strm_rd_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LO_W  = 32,
    parameter int HI_W  = 17,
    parameter int LEN_W = 29,
    parameter int CNT_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_sel,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 mem_req,
    output logic [LO_W+HI_W-1:0] mem_addr,
    input  logic                 mem_rvalid,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_rerr,
    output logic                 s_valid,
    input  logic                 s_ready,
    output logic [DW-1:0]        s_data,
    output logic                 s_last,
    output logic                 busy,
    output logic [2:0]           irq_evt
);
    logic [DW-1:0] rdata_rev;
    logic          paused;

    strm_rd_bswap #(.DW(DW)) u_bswap (
        .din  (mem_rdata),
        .dout (rdata_rev)
    );

    strm_rd_ctl #(
        .DW(DW), .LO_W(LO_W), .HI_W(HI_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
    ) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .mem_rdata_rev (rdata_rev),
        .mem_rerr      (mem_rerr),
        .s_valid       (s_valid),
        .s_ready       (s_ready),
        .s_data        (s_data),
        .s_last        (s_last),
        .busy          (busy),
        .paused        (paused),
        .irq_evt       (irq_evt)
    );

endmodule

// File: rtl/strm_rd_chk.sv
module strm_rd_chk
    import strm_rd_pkg::*;
#(
    parameter int DW     = 32,
    parameter int ADDR_W = 49
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              s_valid,
    input logic              s_ready,
    input logic [DW-1:0]     s_data,
    input logic              s_last,
    input logic              busy,
    input logic              paused,
    input logic [2:0]        irq_evt
);

    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    a_r13_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && !s_ready |=> $stable(s_data));

    a_r13_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && s_valid));

    a_r11_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && !s_ready |=> s_valid || paused);

    a_r11_no_req_paused: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(!paused));

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt[1] |-> !busy);

    a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        s_last |-> s_valid);

    a_r4_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we && reg_sel == SEL_LEN));

endmodule

bind strm_rd_chan strm_rd_chk #(.DW(DW), .ADDR_W(LO_W + HI_W)) u_chk (.*);

// File: tb/strm_rd_chan_tb.sv
`timescale 1ns/1ps
module strm_rd_chan_tb;
    import strm_rd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [48:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_rerr = 1'b0;
    logic        s_valid;
    logic        s_ready = 1'b0;
    logic [31:0] s_data;
    logic        s_last;
    logic        busy;
    logic [2:0]  irq_evt;

    always #2.5 clk = ~clk;

    strm_rd_chan u_dut (.*);

    int checks = 0, fails = 0;
    int ready_pct = 100;
    bit err_en = 0;
    logic [48:0] err_addr = '0;
    int lat = 0;
    int nbeats = 0, n_done = 0, n_mdone = 0, n_err = 0, n_req = 0, n_vcyc = 0;
    logic [31:0] got_d [16];
    bit          got_l [16];
    bit          prev_req = 0;
    logic [31:0] exp_sum = '0;
    logic [2:0]  exp_dcnt = '0;

    logic [31:0] x_lo; logic [16:0] x_hi; int x_nw; bit x_last, x_fix, x_swap;
    int x_d0, x_e0;

    function automatic logic [31:0] mem_word(input logic [48:0] a);
        return (a[31:0] * 32'h9E3779B1 + {15'b0, a[48:32]}) ^ 32'hC3A50F1E;
    endfunction

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory agent, stream sink and event monitor, all at falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (irq_evt[1]) n_done++;
                if (irq_evt[0]) n_mdone++;
                if (irq_evt[2]) n_err++;
                if (mem_req && !prev_req) n_req++;
                prev_req = mem_req;
                if (s_valid) n_vcyc++;
                if (mem_req && !mem_rvalid) begin
                    if (lat == 0) begin
                        mem_rvalid = 1'b1;
                        mem_rdata  = mem_word(mem_addr);
                        mem_rerr   = err_en && (mem_addr == err_addr);
                        lat        = $urandom % 3;
                    end else lat--;
                end else begin
                    mem_rvalid = 1'b0;
                    mem_rerr   = 1'b0;
                end
                begin
                    bit r;
                    r = (ready_pct >= 100) || (($urandom % 100) < ready_pct);
                    if (s_valid && r && nbeats < 16) begin
                        got_d[nbeats] = s_data;
                        got_l[nbeats] = s_last;
                        nbeats++;
                    end
                    s_ready = r;
                end
            end
        end
    end

    task automatic reg_wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic start_xfer(input logic [16:0] hi, input logic [31:0] lo, input int nw,
                              input bit lastf, input bit fixed, input bit swap,
                              input bit pause, input int pct, input int errw);
        x_lo = lo; x_hi = hi; x_nw = nw; x_last = lastf; x_fix = fixed; x_swap = swap;
        ready_pct = pct;
        err_en = (errw >= 0);
        err_addr = {hi, lo} + 49'(4 * (errw < 0 ? 0 : errw));
        reg_wr(SEL_CTRL, {28'b0, swap, fixed, 1'b0, pause});
        reg_wr(SEL_ADDR_LO, lo);
        reg_wr(SEL_ADDR_HI, {15'b0, hi});
        nbeats = 0; x_d0 = n_done; x_e0 = n_err;
        reg_wr(SEL_LEN, (nw * 4) | {31'b0, lastf});
    endtask

    task automatic finish_xfer();
        int cnt = 0;
        int errs = 0;
        logic [31:0] v;
        logic [48:0] a, base;
        while (n_done < x_d0 + 1 && cnt < 4000) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt < 4000, "R7", "completion reached", 64'(n_done), 64'(x_d0 + 1));
        repeat (2) @(negedge clk);
        exp_dcnt = exp_dcnt + 3'd1;
        chk(nbeats == x_nw, "R4", "beat count", 64'(nbeats), 64'(x_nw));
        base = {x_hi, x_lo};
        for (int i = 0; i < x_nw && i < 16; i++) begin
            logic [31:0] w, e;
            bit isb;
            a = x_fix ? base : base + 49'(4 * i);
            w = mem_word(a);
            isb = err_en && (a == err_addr);
            if (isb) errs++; else exp_sum = exp_sum + w;
            e = isb ? w : (x_swap ? rev(w) : w);
            chk(got_d[i] === e, x_swap ? "R10" : (isb ? "R12" : "R4"), "beat data", 64'(got_d[i]), 64'(e));
            chk(got_l[i] == (x_last && i == x_nw - 1), "R8", "end-of-packet", 64'(got_l[i]),
                64'(x_last && i == x_nw - 1));
        end
        chk(n_err - x_e0 == errs, "R12", "read error events", 64'(n_err - x_e0), 64'(errs));
        chk(n_mdone == n_done, "R7", "memory done paired with done", 64'(n_mdone), 64'(n_done));
        reg_rd(SEL_SUM, v);
        chk(v == exp_sum, "R9", "checksum", 64'(v), 64'(exp_sum));
        reg_rd(SEL_STAT, v);
        chk(v == {28'b0, exp_dcnt, 1'b0}, "R7", "status after completion", 64'(v), 64'({exp_dcnt, 1'b0}));
        reg_rd(SEL_LEN, v);
        chk(v == {31'b0, x_last}, "R3", "count readback at end", 64'(v), 64'(x_last));
        a = x_fix ? base : base + 49'(4 * x_nw);
        reg_rd(SEL_ADDR_LO, v);
        chk(v == a[31:0], x_fix ? "R5" : "R4", "low address at end", 64'(v), 64'(a[31:0]));
        reg_rd(SEL_ADDR_HI, v);
        chk(v == {15'b0, a[48:32]}, x_fix ? "R5" : "R4", "high address at end", 64'(v), 64'(a[48:32]));
        err_en = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int r0, v0, d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !mem_req && !s_valid && irq_evt == 0, "R1", "idle outputs", 64'({busy, mem_req, s_valid, irq_evt}), 0);
        reg_rd(SEL_LEN, v);  chk(v == 0, "R1", "count reg", 64'(v), 0);
        reg_rd(SEL_CTRL, v); chk(v == 0, "R1", "control reg", 64'(v), 0);
        reg_rd(SEL_STAT, v); chk(v == 0, "R1", "status reg", 64'(v), 0);
        reg_rd(SEL_SUM, v);  chk(v == 0, "R1", "checksum reg", 64'(v), 0);

        // R2 address masking
        reg_wr(SEL_ADDR_LO, 32'hFFFF_FFFF);
        reg_rd(SEL_ADDR_LO, v); chk(v == 32'hFFFF_FFFC, "R2", "low address alignment", 64'(v), 64'h FFFFFFFC);
        reg_wr(SEL_ADDR_HI, 32'hFFFF_FFFF);
        reg_rd(SEL_ADDR_HI, v); chk(v == 32'h0001_FFFF, "R2", "high address width", 64'(v), 64'h1FFFF);

        // directed transfers
        start_xfer(17'h0, 32'h0000_1000, 4, 1, 0, 0, 0, 100, -1); finish_xfer();
        start_xfer(17'h5, 32'h0000_2000, 3, 0, 0, 1, 0, 60, -1);  finish_xfer();
        start_xfer(17'h0, 32'h0000_3000, 5, 1, 1, 0, 0, 50, -1);  finish_xfer();
        start_xfer(17'h1, 32'hFFFF_FFF8, 4, 1, 0, 0, 0, 100, -1); finish_xfer();
        start_xfer(17'h0, 32'h0000_4000, 4, 0, 0, 1, 0, 100, 2);  finish_xfer();

        // R6 zero length
        d0 = n_done; r0 = n_req;
        reg_wr(SEL_LEN, 32'h1);
        repeat (3) @(negedge clk);
        exp_dcnt = exp_dcnt + 3'd1;
        chk(n_done == d0 + 1 && n_mdone == n_done, "R6", "zero count done events", 64'(n_done), 64'(d0 + 1));
        chk(n_req == r0, "R6", "zero count issues no read", 64'(n_req), 64'(r0));
        reg_rd(SEL_STAT, v);
        chk(v == {28'b0, exp_dcnt, 1'b0}, "R6", "zero count status", 64'(v), 64'({exp_dcnt, 1'b0}));

        // R9 checksum write while idle
        reg_wr(SEL_SUM, 32'h0);
        exp_sum = '0;
        reg_rd(SEL_SUM, v); chk(v == 0, "R9", "checksum cleared by write", 64'(v), 0);

        // R3 count and address writes ignored while busy
        start_xfer(17'h2, 32'h0000_5000, 6, 0, 0, 0, 0, 0, -1);
        repeat (10) @(negedge clk);
        reg_wr(SEL_LEN, 32'h8);
        reg_wr(SEL_ADDR_LO, 32'h0000_9000);
        reg_wr(SEL_SUM, 32'h1234_5678);
        reg_rd(SEL_LEN, v);     chk(v == 32'd24, "R3", "count write while busy ignored", 64'(v), 24);
        reg_rd(SEL_ADDR_LO, v); chk(v == 32'h0000_5000, "R2", "address write while busy ignored", 64'(v), 64'h5000);
        ready_pct = 100;
        finish_xfer();

        // R11 memory pause before start
        r0 = n_req;
        start_xfer(17'h0, 32'h0000_6000, 3, 1, 0, 0, 1, 100, -1);
        repeat (20) @(negedge clk);
        chk(n_req == r0, "R11", "no read while paused", 64'(n_req), 64'(r0));
        reg_rd(SEL_STAT, v); chk(v[0] == 1'b1, "R11", "busy while paused", 64'(v[0]), 1);
        reg_wr(SEL_CTRL, 32'h0);
        finish_xfer();

        // R11 stream pause mid-transfer
        start_xfer(17'h3, 32'h0000_7000, 8, 1, 0, 1, 0, 100, -1);
        while (nbeats < 2) @(negedge clk);
        reg_wr(SEL_CTRL, 32'h0000_000A);
        v0 = n_vcyc; r0 = nbeats;
        repeat (15) @(negedge clk);
        chk(n_vcyc == v0 && nbeats == r0, "R11", "no valid during stream pause", 64'(n_vcyc), 64'(v0));
        reg_wr(SEL_CTRL, 32'h0000_0008);
        finish_xfer();

        // random transfers
        for (int k = 0; k < 10; k++) begin
            logic [31:0] lo;
            lo = $urandom & 32'hFFFF_FFFC;
            start_xfer(17'($urandom), lo, 1 + ($urandom % 7), 1'($urandom), 1'($urandom),
                       1'($urandom), 0, 30 + ($urandom % 71), ($urandom % 3 == 0) ? int'($urandom % 4) : -1);
            finish_xfer();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
    end

endmodule